// File: doc/BRIEF.md
# Serial Nibble Register File Peripheral

This block is the device end of a three-wire serial link: a chip-enable, a clock driven by the host, and a data line that the host and the device take turns driving. Behind the link sit sixteen 4-bit registers laid out like a clock/calendar part. Fourteen of them are plain storage for time digits, weekday and an interval setting. The other two are a control register and a test register. No timekeeping or interrupt logic is present: values are written, held and read back, and the only behaviour besides storage is in the control-register flags.

The host frames every transfer in 8-bit command bytes, MSB first, each bit taken on a rising edge of the serial clock. Bit 6 of a byte marks a read, bit 5 marks an address phase, bit 4 marks a data phase, and bits 3:0 carry an address or a data nibble. A write is an address byte (bit 5 set, bit 6 clear) followed by a data byte (bit 4 set). A read is an address byte with bits 6 and 5 set, after which the device drives eight bit times: four zeros, then the nibble. The serial inputs are synchronised to the system clock, so the serial clock must be slow against it (each serial clock phase at least four system clocks).

The control register (address 0xE) reads as {counter flag, hour mode, oscillator stop, busy} from bit 3 down to bit 0. Writing 1 to bit 0 starts an adjust window during which busy reads 1 and the time registers refuse writes. The oscillator-stop flag is set by reset and cleared by writing 0 to bit 1. The test register (address 0xF) forces busy from its bit 0 and sets the oscillator-stop flag from its bit 1. The link state machine has four states. ST_IDLE: chip-enable low, with nothing driven. ST_IDLE goes to ST_CMD once chip-enable is high. ST_CMD takes command bytes. An address byte goes to ST_WDATA (no read bit) or ST_READ (read bit set), and any other byte stays in ST_CMD. ST_WDATA takes the data byte and returns to ST_CMD. ST_READ shifts out eight bits and returns to ST_CMD. From every state, chip-enable low goes to ST_IDLE.

Top module: `snr_periph`

## Requirements
- R1: While chip-enable is low the data line is not driven (sda_oe is 0), and the bit counter and phase state are cleared, so a partial byte left when chip-enable falls is discarded.
- R2: An address byte with bit 5 set and bit 6 clear, followed by a data byte with bit 4 set, stores the low nibble of the data byte at the address held in the low nibble of the address byte. Bits arrive MSB first and are taken on the serial clock rising edge.
- R3: An address byte with bits 6 and 5 set makes the device drive the data line for exactly the next eight bit times, MSB first: four zero bits and then the 4-bit register value. Each bit changes only after a serial clock rising edge, and sda_oe is 0 outside these eight bit times.
- R4: A byte in command position with bit 5 clear has no effect. A byte following a write address that has bit 4 clear discards that write.
- R5: After reset all storage registers and the test register read 0, and the control register reads 0x2 (oscillator stop set, busy clear).
- R6: Writing the control register with bit 0 set makes busy (control bit 0) read 1 for BUSY_CYCLES system clocks, after which it reads 0.
- R7: While busy is 1, writes to addresses 0x0 to 0xD are dropped, but writes to the control register (0xE) and the test register (0xF) still take effect.
- R8: Writing the control register with bit 1 clear clears the oscillator-stop flag. Writing bit 1 as 1 never sets it.
- R9: The test register stores what is written. While its bit 0 is 1, busy reads 1. Writing its bit 1 as 1 sets the oscillator-stop flag, which stays set after the test bit is cleared.
- R10: Control bits 2 (hour mode) and 3 (counter flag) store the written value and read it back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce | input | 1 | Chip-enable from the host, active high |
| scl | input | 1 | Serial clock from the host |
| sda_in | input | 1 | Data line as seen at the pin |
| sda_out | output | 1 | Data value the device drives during a read |
| sda_oe | output | 1 | Drive enable for the data line |

## Verification
The corner cases targeted are a chip-enable drop in the middle of a byte, and one in the middle of a read. A design that kept its bit count would misalign every later byte, and one that kept driving would fight the host on the data line. Junk bytes without the address flag, and data bytes without the data flag, are mixed into random traffic. A decoder that ignored those flag bits would corrupt registers or start phantom reads. The busy window is probed from both sides: a time-register write inside it must leave the old value, while control and test writes inside it must land. A design that gated all writes, or none, shows a wrong read-back. The oscillator-stop flag is written with 1 after being cleared, and it is also forced through the test register, which catches a flag that could be set from the wrong path or fell back when the force was lifted.

// File: rtl/snr_pkg.sv
package snr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CMD   = 2'd1,
        ST_WDATA = 2'd2,
        ST_READ  = 2'd3
    } snr_state_e;

    localparam int NIB_W      = 4;
    localparam int BYTE_W     = 8;
    localparam int CMD_RD_BIT = 6;
    localparam int CMD_AD_BIT = 5;
    localparam int CMD_DT_BIT = 4;

    localparam logic [NIB_W-1:0] ADDR_CTL  = 4'hE;
    localparam logic [NIB_W-1:0] ADDR_TST  = 4'hF;
    localparam int               N_PLAIN   = 14;

    localparam int CTL_BUSY  = 0;
    localparam int CTL_STOP  = 1;
    localparam int CTL_MODE  = 2;
    localparam int CTL_CFLAG = 3;

endpackage

// File: rtl/snr_sync.sv
module snr_sync #(
    parameter int           W       = 3,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic [STAGES-1:0] chain;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain <= {STAGES{RST_VAL[i]}};
            end else begin
                chain <= {chain[STAGES-2:0], d[i]};
            end
        end

        assign q[i] = chain[STAGES-1];
    end

endmodule

// File: rtl/snr_link.sv
module snr_link
    import snr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ce_q,
    input  logic             scl_q,
    input  logic             sda_q,
    input  logic [NIB_W-1:0] rd_data,
    output logic [NIB_W-1:0] rd_addr,
    output logic             scl_rise,
    output logic             wr_en,
    output logic [NIB_W-1:0] wr_addr,
    output logic [NIB_W-1:0] wr_data,
    output logic             sda_out,
    output logic             sda_oe
);

    localparam int CNT_W = $clog2(BYTE_W);

    snr_state_e          state_q, state_d;
    logic                scl_d;
    logic [CNT_W-1:0]    bit_cnt;
    logic [5:0]          shreg;
    logic [6:0]          byte_in;
    logic                byte_end;
    logic                is_addr, is_read, is_data;
    logic [NIB_W-1:0]    addr_q;
    logic [BYTE_W-1:0]   tx_q;

    assign scl_rise = scl_q & ~scl_d;
    assign byte_in  = {shreg, sda_q};
    assign byte_end = scl_rise && (bit_cnt == CNT_W'(BYTE_W - 1));
    assign is_addr  = byte_in[CMD_AD_BIT];
    assign is_read  = byte_in[CMD_RD_BIT];
    assign is_data  = byte_in[CMD_DT_BIT];
    assign rd_addr  = byte_in[NIB_W-1:0];
    assign wr_addr  = addr_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        if (!ce_q) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_CMD;
                ST_CMD: begin
                    if (byte_end && is_addr) begin
                        state_d = is_read ? ST_READ : ST_WDATA;
                    end
                end
                ST_WDATA: if (byte_end) state_d = ST_CMD;
                ST_READ:  if (byte_end) state_d = ST_CMD;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    // Outputs
    always_comb begin
        sda_oe  = (state_q == ST_READ);
        sda_out = sda_oe & tx_q[BYTE_W-1];
    end

    // Shift, decode and write strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_d   <= 1'b1;
            bit_cnt <= '0;
            shreg   <= '0;
            addr_q  <= '0;
            tx_q    <= '0;
            wr_en   <= 1'b0;
            wr_data <= '0;
        end else begin
            scl_d <= scl_q;
            wr_en <= 1'b0;

            if (!ce_q) begin
                bit_cnt <= '0;
                shreg   <= '0;
            end else if (scl_rise) begin
                bit_cnt <= bit_cnt + 1'b1;
                shreg   <= byte_in[5:0];
            end

            if (ce_q && state_q == ST_CMD && byte_end && is_addr) begin
                addr_q <= byte_in[NIB_W-1:0];
                tx_q   <= {{(BYTE_W-NIB_W){1'b0}}, rd_data};
            end else if (state_q == ST_READ && scl_rise) begin
                tx_q <= {tx_q[BYTE_W-2:0], 1'b0};
            end

            if (ce_q && state_q == ST_WDATA && byte_end && is_data) begin
                wr_en   <= 1'b1;
                wr_data <= byte_in[NIB_W-1:0];
            end
        end
    end

endmodule

// File: rtl/snr_regs.sv
module snr_regs
    import snr_pkg::*;
#(
    parameter int BUSY_CYCLES = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [NIB_W-1:0] wr_addr,
    input  logic [NIB_W-1:0] wr_data,
    input  logic [NIB_W-1:0] rd_addr,
    output logic [NIB_W-1:0] rd_data
);

    localparam int CW = $clog2(BUSY_CYCLES + 1);

    logic [NIB_W-1:0] cells [N_PLAIN];
    logic [CW-1:0]    adj_cnt;
    logic [NIB_W-1:0] test_q;
    logic             stop_q, mode_q, cflag_q;
    logic             busy;
    logic             plain_wr, ctl_wr, tst_wr;

    assign busy     = (adj_cnt != '0) | test_q[0];
    assign plain_wr = wr_en && (wr_addr < NIB_W'(N_PLAIN)) && !busy;
    assign ctl_wr   = wr_en && (wr_addr == ADDR_CTL);
    assign tst_wr   = wr_en && (wr_addr == ADDR_TST);

    for (genvar i = 0; i < N_PLAIN; i++) begin : g_cell
        logic [NIB_W-1:0] cell_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cell_q <= '0;
            end else if (plain_wr && wr_addr == NIB_W'(i)) begin
                cell_q <= wr_data;
            end
        end

        assign cells[i] = cell_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            adj_cnt <= '0;
            mode_q  <= 1'b0;
            cflag_q <= 1'b0;
            stop_q  <= 1'b1;
            test_q  <= '0;
        end else begin
            if (ctl_wr && wr_data[CTL_BUSY]) begin
                adj_cnt <= CW'(BUSY_CYCLES);
            end else if (adj_cnt != '0) begin
                adj_cnt <= adj_cnt - 1'b1;
            end

            if (ctl_wr) begin
                mode_q  <= wr_data[CTL_MODE];
                cflag_q <= wr_data[CTL_CFLAG];
            end

            if (test_q[1]) begin
                stop_q <= 1'b1;
            end else if (ctl_wr && !wr_data[CTL_STOP]) begin
                stop_q <= 1'b0;
            end

            if (tst_wr) begin
                test_q <= wr_data;
            end
        end
    end

    always_comb begin
        unique case (rd_addr)
            ADDR_CTL: rd_data = {cflag_q, mode_q, stop_q, busy};
            ADDR_TST: rd_data = test_q;
            default:  rd_data = cells[rd_addr];
        endcase
    end

endmodule

// File: rtl/snr_periph.sv
module snr_periph
    import snr_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int BUSY_CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ce,
    input  logic scl,
    input  logic sda_in,
    output logic sda_out,
    output logic sda_oe
);

    logic [2:0]       pins_q;
    logic             ce_q, scl_q, sda_q;
    logic             scl_rise;
    logic             wr_en;
    logic [NIB_W-1:0] wr_addr, wr_data, rd_addr, rd_data;

    snr_sync #(
        .W       (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b010)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({sda_in, scl, ce}),
        .q     (pins_q)
    );

    assign ce_q  = pins_q[0];
    assign scl_q = pins_q[1];
    assign sda_q = pins_q[2];

    snr_link u_link (
        .clk      (clk),
        .rst_n    (rst_n),
        .ce_q     (ce_q),
        .scl_q    (scl_q),
        .sda_q    (sda_q),
        .rd_data  (rd_data),
        .rd_addr  (rd_addr),
        .scl_rise (scl_rise),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .sda_out  (sda_out),
        .sda_oe   (sda_oe)
    );

    snr_regs #(
        .BUSY_CYCLES (BUSY_CYCLES)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

endmodule

// File: rtl/snr_periph_chk.sv
module snr_periph_chk (
    input logic clk,
    input logic rst_n,
    input logic ce_q,
    input logic scl_rise,
    input logic wr_en,
    input logic sda_out,
    input logic sda_oe
);

    AST_CE_LOW_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !ce_q |=> !sda_oe); // R1

    AST_CE_LOW_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !ce_q |=> !wr_en); // R1

    AST_WRITE_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(scl_rise)); // R2

    AST_WRITE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en); // R2

    AST_DRIVE_STARTS_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> $past(scl_rise)); // R3

    AST_DRIVE_HOLDS_BETWEEN_EDGES: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe && !scl_rise) |=> (!sda_oe || $stable(sda_out))); // R3

endmodule

bind snr_periph snr_periph_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ce_q     (ce_q),
    .scl_rise (scl_rise),
    .wr_en    (wr_en),
    .sda_out  (sda_out),
    .sda_oe   (sda_oe)
);

// File: tb/snr_periph_tb.sv
module snr_periph_tb;

    localparam int BUSY = 1500;
    localparam int HALF = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce = 1'b0;
    logic scl = 1'b1;
    logic sda_in = 1'b0;
    logic sda_out, sda_oe;

    int nchecks = 0;
    int nfail = 0;
    bit done = 1'b0;

    logic [3:0] m_mem [14];
    logic       m_mode, m_cflag, m_stop, m_adj;
    logic [3:0] m_test;

    always #2 clk = ~clk;

    snr_periph #(.SYNC_STAGES(2), .BUSY_CYCLES(BUSY)) u_dut (
        .clk(clk), .rst_n(rst_n), .ce(ce), .scl(scl),
        .sda_in(sda_in), .sda_out(sda_out), .sda_oe(sda_oe)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        nchecks++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic m_busy();
        return m_adj | m_test[0];
    endfunction

    function automatic logic [3:0] exp_nib(input logic [3:0] a);
        if (a == 4'hE) return {m_cflag, m_mode, m_stop, m_busy()};
        if (a == 4'hF) return m_test;
        return m_mem[a];
    endfunction

    task automatic send_bit(input logic b);
        scl = 1'b0; sda_in = b; tick(HALF);
        scl = 1'b1; tick(HALF);
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
    endtask

    task automatic ce_on();
        ce = 1'b1; tick(HALF);
    endtask

    task automatic ce_off();
        ce = 1'b0; tick(HALF);
    endtask

    task automatic wr_reg(input logic [3:0] a, input logic [3:0] d);
        send_byte({4'h2, a});
        send_byte({4'h1, d});
        if (a < 4'd14) begin
            if (!m_busy()) m_mem[a] = d;
        end else if (a == 4'hE) begin
            m_mode = d[2]; m_cflag = d[3];
            if (d[0]) m_adj = 1'b1;
            if (!d[1] && !m_test[1]) m_stop = 1'b0;
        end else begin
            m_test = d;
            if (d[1]) m_stop = 1'b1;
        end
    endtask

    task automatic rd_check(input logic [3:0] a, input string tag);
        logic [7:0] v;
        bit oe_all;
        v = '0; oe_all = 1'b1;
        send_byte({4'h6, a});
        for (int k = 0; k < 8; k++) begin
            v = {v[6:0], sda_out};
            if (!sda_oe) oe_all = 1'b0;
            scl = 1'b0; tick(HALF);
            scl = 1'b1; tick(HALF);
        end
        chk(tag, int'(v), int'({4'h0, exp_nib(a)}));
        chk({tag, " drive window"}, int'(oe_all), 1);
        chk({tag, " release"}, int'(sda_oe), 0);
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nchecks++;
        nfail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        report();
    end

    initial begin
        logic [31:0] r;
        for (int i = 0; i < 14; i++) m_mem[i] = 4'h0;
        m_mode = 1'b0; m_cflag = 1'b0; m_stop = 1'b1; m_adj = 1'b0; m_test = 4'h0;
        r = $urandom(32'h5EED_0042);

        tick(10);
        chk("R1 oe in reset", int'(sda_oe), 0);
        rst_n = 1'b1;
        tick(4);
        ce_on();

        // R5 reset contents
        rd_check(4'hE, "R5 control after reset");
        rd_check(4'h0, "R5 seconds after reset");
        rd_check(4'hF, "R5 test after reset");

        // R2 plain writes
        wr_reg(4'h3, 4'h7);
        rd_check(4'h3, "R2 write 0x3");
        wr_reg(4'hD, 4'h9);
        rd_check(4'hD, "R2 write 0xD");

        // R8 stop flag
        wr_reg(4'hE, 4'h2);
        rd_check(4'hE, "R8 write 1 keeps stop");
        wr_reg(4'hE, 4'h0);
        rd_check(4'hE, "R8 write 0 clears stop");
        wr_reg(4'hE, 4'h2);
        rd_check(4'hE, "R8 write 1 does not set");

        // R10 mode and counter flag
        wr_reg(4'hE, 4'hC);
        rd_check(4'hE, "R10 control bits 3:2");
        wr_reg(4'hE, 4'h0);

        // R4 ignored bytes
        send_byte(8'h9A);
        rd_check(4'hA, "R4 byte without address flag");
        send_byte({4'h2, 4'h1});
        send_byte(8'h05);
        rd_check(4'h1, "R4 data byte without data flag");

        // R1 partial byte dropped by chip-enable
        send_bit(1'b1); send_bit(1'b1); send_bit(1'b1);
        ce_off();
        chk("R1 oe with ce low", int'(sda_oe), 0);
        ce_on();
        wr_reg(4'h2, 4'h9);
        rd_check(4'h2, "R1 realigned after partial byte");

        // R1 chip-enable drop mid-read
        send_byte(8'h62);
        chk("R3 drive during read", int'(sda_oe), 1);
        ce = 1'b0; tick(HALF);
        chk("R1 release on ce drop", int'(sda_oe), 0);
        ce_on();
        rd_check(4'h2, "R1 state after aborted read");

        // R6 and R7 adjust window
        wr_reg(4'hE, 4'h1);
        rd_check(4'hE, "R6 busy set");
        wr_reg(4'h4, 4'hA);
        wr_reg(4'hE, 4'h8);
        rd_check(4'hE, "R7 control write while busy");
        tick(BUSY + 200);
        m_adj = 1'b0;
        rd_check(4'hE, "R6 busy expired");
        rd_check(4'h4, "R7 time write dropped while busy");
        wr_reg(4'h4, 4'hA);
        rd_check(4'h4, "R7 time write after busy");

        // R9 test register forcing
        wr_reg(4'hF, 4'h1);
        rd_check(4'hE, "R9 forced busy");
        rd_check(4'hF, "R9 test read back");
        wr_reg(4'h6, 4'h3);
        wr_reg(4'hF, 4'h2);
        rd_check(4'hE, "R9 forced stop");
        rd_check(4'h6, "R9 write dropped under forced busy");
        wr_reg(4'hF, 4'h0);
        rd_check(4'hE, "R9 stop stays after release");
        wr_reg(4'hE, 4'h8);
        rd_check(4'hE, "R8 clear after force");

        // Random traffic
        for (int n = 0; n < 140; n++) begin
            logic [3:0] a, d;
            int op;
            op = int'($urandom % 8);
            a = 4'($urandom % 15);
            d = 4'($urandom);
            unique case (op)
                0, 1, 2, 3: begin
                    if (a == 4'hE) d[0] = 1'b0;
                    wr_reg(a, d);
                end
                4, 5: rd_check(4'($urandom % 16), "R3 random read");
                6: begin
                    send_byte({2'($urandom), 1'b0, 5'($urandom)});
                    rd_check(a, "R4 random junk byte");
                end
                default: begin
                    send_byte({4'h2, a});
                    send_byte({2'($urandom), 2'b00, d});
                    rd_check(a, "R4 random dropped data");
                end
            endcase
        end
        for (int i = 0; i < 14; i++) rd_check(4'(i), "R2 final contents");

        ce_off();
        report();
    end

endmodule